// File: doc/BRIEF.md
# Sized-Store Word Data Memory

This block is a data memory organised as an array of 32-bit words. One access is made per clock. A 2-bit size code on each access says whether it is a read only, or a write of one byte, of a halfword, or of a full word. The two low address bits pick the byte lanes that a sub-word store touches. Only those lanes change, so a byte or halfword store merges into the word already held. The other lanes keep their contents.

The word index comes from the address bits just above bit 1. The number of words is a parameter, and it must be a power of two. Address bits above the index do not take part in decoding. Every read returns the whole aligned word.

A parameter selects how read data comes out. By default the word is registered at the clock edge and appears one cycle after the address. In that mode the register captures the contents as they were before any write committed at the same edge. The other setting gives a combinational read.

Top module: `dmem_sized`

## Requirements
- R1: A size code of 00 performs no write. The stored word keeps its contents whatever the address and write data are.
- R2: A size code of 01 writes wr_data[7:0] into byte lane addr[1:0] of the addressed word. Lane n occupies word bits [8n+7:8n].
- R3: A size code of 10 writes wr_data[15:0] into the lower half, bits [15:0], when addr[1] is 0. It writes them into the upper half, bits [31:16], when addr[1] is 1. addr[0] is ignored.
- R4: A size code of 11 writes all 32 bits of wr_data into the addressed word. addr[1:0] are ignored.
- R5: Byte lanes outside the ones selected by a byte or halfword write keep their previous contents.
- R6: A read returns the whole aligned word regardless of addr[1:0].
- R7: The word index is addr[IDX_W+1:2], with IDX_W = log2(DEPTH). Address bits above the index are ignored, so addresses that differ only there reach the same word.
- R8: With registered read (the default), rd_data shows the word addressed in the previous cycle. If that cycle also wrote the word, rd_data shows the contents from before that write.
- R9: Reset is synchronous and active low. While it is held, rd_data reads 0 and no write is performed. Stored words are not cleared.
- R10: A write commits at the rising clock edge. A read of the same word issued in the following cycle returns the merged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every write and the read register act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 32 | Byte address of the access |
| size_ctl | input | 2 | 00 read only, 01 byte write, 10 halfword write, 11 word write |
| wr_data | input | 32 | Store data, right-aligned for sub-word writes |
| rd_data | output | 32 | Aligned word read from the addressed index |

## Verification
The assertions check several properties on every cycle. The lane-enable pattern must match each size code: no lanes for 00, exactly one lane for 01, one aligned pair for 10 and all four for 11. A word at an unchanged index must keep its contents across a cycle that enables no lane. A full-word write followed by an idle read of the same index must return the stored data. Reset must force rd_data to zero. Other properties only show up in the bench's scenarios, because they depend on the history of stored values. These are the merging of sub-word stores into older data, address aliasing above the index, the read-first ordering at a shared edge, and words surviving a reset. The bench drives random sizes, addresses and data against a word-level reference model.

// File: rtl/dmem_pkg.sv
// Shared constants and the access size encoding for the sized-store data memory.
// Assumes a 32-bit word made of four 8-bit lanes.
package dmem_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int OFS_W  = 2;

    typedef enum logic [1:0] {
        SZ_NONE = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_WORD = 2'b11
    } size_code_e;
endpackage

// File: rtl/dmem_lane_dec.sv
// Turns a size code and the low address bits into per-lane write enables.
// Also steers the right-aligned store data onto the lanes it will land in.
// Assumes wr_allow is low during reset, so that no lane is enabled then.
module dmem_lane_dec
    import dmem_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  size_code_e           size_code,
    input  logic [OFS_W-1:0]     lane_sel,
    input  logic                 wr_allow,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [LANES-1:0]     lane_en,
    output logic [WORD_W-1:0]    lane_data
);

    // Enable generation: byte picks one lane, half picks an aligned pair, word picks all.
    always_comb begin
        lane_en = '0;
        if (wr_allow) begin
            unique case (size_code)
                SZ_BYTE: lane_en[lane_sel] = 1'b1;
                SZ_HALF: lane_en = lane_sel[1] ? 4'b1100 : 4'b0011;
                SZ_WORD: lane_en = '1;
                default: lane_en = '0;
            endcase
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [BYTE_W-1:0] lane_b;
        // Data steering: replicate the low byte or the low halfword so every candidate lane sees it.
        always_comb begin
            unique case (size_code)
                SZ_BYTE: lane_b = wr_data[BYTE_W-1:0];
                SZ_HALF: lane_b = wr_data[(l % 2) * BYTE_W +: BYTE_W];
                default: lane_b = wr_data[l * BYTE_W +: BYTE_W];
            endcase
        end
        assign lane_data[l * BYTE_W +: BYTE_W] = lane_b;
    end

    assert_idle_no_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == SZ_NONE) |-> (lane_en == '0));
    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == SZ_BYTE) |-> ($countones(lane_en) == 1 && lane_en[lane_sel]));
    assert_half_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == SZ_HALF) |-> ($countones(lane_en) == 2 && lane_en[{lane_sel[1], 1'b0}]
                                     && lane_en[{lane_sel[1], 1'b1}]));
    assert_word_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (size_code == SZ_WORD) |-> (&lane_en));
endmodule

// File: rtl/dmem_store.sv
// Word storage built as one byte-wide bank per lane.
// Each bank is written only when its lane enable is set. All banks share the word index.
// Assumes DEPTH equals 2**IDX_W. Contents are not reset.
module dmem_store
    import dmem_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     idx,
    input  logic [LANES-1:0]     lane_en,
    input  logic [WORD_W-1:0]    lane_data,
    output logic [WORD_W-1:0]    rd_word
);

    for (genvar l = 0; l < LANES; l++) begin : g_bank
        logic [BYTE_W-1:0] bank [DEPTH];
        // Lane write: commit the steered byte at the rising edge when enabled.
        always_ff @(posedge clk) begin
            if (lane_en[l]) bank[idx] <= lane_data[l * BYTE_W +: BYTE_W];
        end
        assign rd_word[l * BYTE_W +: BYTE_W] = bank[idx];
    end

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lane_en) == '0 && $past(idx) == idx && !$isunknown($past(rd_word)))
        |-> (rd_word == $past(rd_word)));
endmodule

// File: rtl/dmem_rd_port.sv
// Read output stage. It is either a reset-to-zero register that samples the word
// before the same-edge write, or a plain combinational pass-through.
module dmem_rd_port
    import dmem_pkg::*;
#(
    parameter bit REG_READ = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WORD_W-1:0]    word_in,
    output logic [WORD_W-1:0]    rd_data
);

    if (REG_READ) begin : g_reg
        logic [WORD_W-1:0] rd_q;
        // Read register: clear under reset, otherwise capture the pre-write word.
        always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= word_in;
        end
        assign rd_data = rd_q;

        assert_reset_clears_R9: assert property (@(posedge clk)
            (!rst_n) |=> (rd_data == '0));
    end else begin : g_comb
        logic unused_rd;
        assign unused_rd = clk ^ rst_n;
        assign rd_data   = word_in;
    end
endmodule

// File: rtl/dmem_sized.sv
// Top of the sized-store data memory.
// It splits the byte address into a lane offset and a word index. Bits above the index
// are dropped. The lane decoder, the banked storage and the read stage hang below it.
// Assumes DEPTH is a power of two below 2**30.
module dmem_sized
    import dmem_pkg::*;
#(
    parameter int DEPTH    = 256,
    parameter bit REG_READ = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] addr,
    input  logic [1:0]  size_ctl,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  idx;
    logic [OFS_W-1:0]  ofs;
    logic [LANES-1:0]  lane_en;
    logic [WORD_W-1:0] lane_data;
    logic [WORD_W-1:0] rd_word;
    logic              unused_hi;
    size_code_e        size_code;

    assign idx       = addr[IDX_W+OFS_W-1:OFS_W];
    assign ofs       = addr[OFS_W-1:0];
    assign unused_hi = ^addr[31:IDX_W+OFS_W];
    assign size_code = size_code_e'(size_ctl);

    dmem_lane_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .size_code (size_code),
        .lane_sel  (ofs),
        .wr_allow  (rst_n),
        .wr_data   (wr_data),
        .lane_en   (lane_en),
        .lane_data (lane_data)
    );

    dmem_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .lane_en   (lane_en),
        .lane_data (lane_data),
        .rd_word   (rd_word)
    );

    dmem_rd_port #(.REG_READ(REG_READ)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_in (rd_word),
        .rd_data (rd_data)
    );

    if (REG_READ) begin : g_chk_reg
        assert_word_write_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (size_ctl == SZ_NONE && $past(size_ctl) == SZ_WORD && $past(rst_n)
             && idx == $past(idx)) |=> (rd_data == $past(wr_data, 2)));
    end
endmodule

// File: tb/tb_dmem_sized.sv
`timescale 1ns/1ps
module tb_dmem_sized;
    localparam int DEPTH = 256;
    localparam int IW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  size_ctl = 2'b00;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model [DEPTH];
    bit          known [DEPTH];

    always #4 clk = ~clk;

    dmem_sized #(.DEPTH(DEPTH), .REG_READ(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .size_ctl(size_ctl),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] sz,
                                          input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] r = old;
        case (sz)
            2'b01: r[a[1:0] * 8 +: 8]  = wd[7:0];
            2'b10: r[a[1] * 16 +: 16]  = wd[15:0];
            2'b11: r = wd;
            default: r = old;
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at negedge, the edge registers the pre-write word, compare at next negedge.
    task automatic step(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd,
                        input string tag);
        int i = int'(a[IW+1:2]);
        logic [31:0] exp = model[i];
        bit chk = known[i];
        size_ctl = sz; addr = a; wr_data = wd;
        if (sz != 2'b00) begin
            model[i] = merge(model[i], sz, a, wd);
            if (sz == 2'b11) known[i] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        if (chk) check(tag, rd_data, exp);
    endtask

    initial begin
        for (int k = 0; k < DEPTH; k++) known[k] = 1'b0;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check("R9 reset output", rd_data, 32'h0);
        rst_n = 1'b1;

        // fill every word with a known value
        for (int k = 0; k < DEPTH; k++) step(2'b11, k * 4, 32'hA5A5_0000 ^ k, "R4 fill");

        // R4: word write with nonzero low address bits
        step(2'b11, 32'h0000_0013, 32'h1122_3344, "R4 word ofs3");
        step(2'b00, 32'h0000_0010, 32'h0, "R4 word readback");
        step(2'b00, 32'h0000_0010, 32'h0, "R10 merged visible");

        // R2/R5: bytes into each lane of word 5
        for (int l = 0; l < 4; l++) begin
            step(2'b01, 32'h14 + l, 32'hFFFF_FF00 | (8'h60 + l), "R2 byte lane");
            step(2'b00, 32'h14, 32'h0, "R5 other lanes kept");
        end
        step(2'b00, 32'h14, 32'h0, "R2 byte final");

        // R3: halfwords, addr[0] set
        step(2'b10, 32'h21, 32'hDEAD_BEEF, "R3 half low");
        step(2'b10, 32'h23, 32'h1234_CAFE, "R3 half high");
        step(2'b00, 32'h20, 32'h0, "R3 half result");
        step(2'b00, 32'h20, 32'h0, "R3 half result again");

        // R1: idle code with data never writes
        step(2'b00, 32'h30, 32'hFFFF_FFFF, "R1 idle");
        step(2'b00, 32'h30, 32'h0000_0000, "R1 no write");
        step(2'b00, 32'h30, 32'h0000_0000, "R1 unchanged");

        // R6: reads at every offset return the aligned word
        for (int o = 0; o < 4; o++) step(2'b00, 32'h40 + o, 32'h0, "R6 aligned read");
        step(2'b00, 32'h40, 32'h0, "R6 last");

        // R7: aliasing above the index
        step(2'b11, 32'h8000_0000 | (32'd9 << 2), 32'h0BAD_F00D, "R7 alias write");
        step(2'b00, 32'h0000_0000 | (32'd9 << 2), 32'h0, "R7 alias prev");
        step(2'b00, 32'h0000_0000 | (32'd9 << 2), 32'h0, "R7 alias read");

        // R8: write and read same word back to back: first result is pre-write data
        step(2'b00, 32'h50, 32'h0, "R8 prime");
        step(2'b11, 32'h50, 32'h7777_8888, "R8 read-first");
        step(2'b00, 32'h50, 32'h0, "R8 new value");
        step(2'b00, 32'h50, 32'h0, "R8 settle");

        // R9: reset mid-run blocks writes, clears output, keeps contents
        rst_n = 1'b0; size_ctl = 2'b11; addr = 32'h60; wr_data = 32'hFEED_FACE;
        @(posedge clk); @(negedge clk);
        check("R9 output zero in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        step(2'b00, 32'h60, 32'h0, "R9 discard");
        step(2'b00, 32'h60, 32'h0, "R9 contents kept");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] a  = $urandom;
            logic [31:0] wd = $urandom;
            logic [1:0]  sz = 2'($urandom_range(0, 3));
            a[31:IW+2] = 0;
            a[IW+1:2]  = 8'($urandom_range(0, 15));
            step(sz, a, wd, "R8 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule